// File: doc/BRIEF.md
# Host Schedule Enable and Doorbell Handshake

This block sits between the host controller's software-visible command bits and the status flags that software reads back. Software uses one register write port to reach two registers. The command register holds the run/stop bit, the periodic schedule enable, the asynchronous schedule enable and the async-advance doorbell. The status register has one write-1-to-clear event bit. The block reports a halted flag, a status flag for each schedule and the async-advance event.

A simplified schedule walker drives three inputs:
- `walk_safe` marks cycles on which the engine is at an idle or safe point. Schedule status may change only on these cycles.
- `walk_busy` marks a walker step that is still in progress. A stop waits for it to finish.
- `evict_done` reports that the asynchronous schedule has advanced and all cached schedule state has been evicted.

Status flags therefore trail their enable bits. A flag equal to its enable means the transition has finished. The doorbell clears only after the event it requests has been posted.

Top module: `hc_sched_handshake`

## Requirements
- R1: After a synchronous reset the block is in this state:
  - `cmd_rd` reads 0.
  - `sts_rd` reads 0x01: halted is 1, and both schedule status flags and the advance event are 0.
- R2: A write with `wr_sel`=0 loads the command register as follows:
  - run from `wr_data` bit 0, periodic enable from bit 1, and asynchronous enable from bit 2.
  - `cmd_rd` returns these three bits at the same positions.
  - Bit 4 is the light-reset bit. It always reads 0, whatever is written.
- R3: Each schedule status flag is reported in `sts_rd`, periodic at bit 1 and asynchronous at bit 2.
  - On a clock edge with `walk_safe`=1, the flag takes the value of its enable bit.
  - On any other edge the flag holds, even if its enable bit has changed.
- R4: The doorbell is `cmd_rd` bit 3.
  - A command write with bit 3 set sets the doorbell only while the asynchronous status flag is 1.
  - While that flag is 0, the ring is ignored and nothing is latched.
  - Writing 0 to bit 3 never clears a pending doorbell.
- R5: The advance event is `sts_rd` bit 3.
  - It is set on an edge where `evict_done`=1 while the doorbell is pending.
  - `evict_done` with no pending doorbell has no effect.
- R6: Hardware clears the doorbell on the edge after the one that set the advance event. It never clears it earlier.
- R7: A write with `wr_sel`=1 and `wr_data` bit 3 set clears the advance event.
  - Writing 0 to bit 3 leaves the event unchanged.
  - If hardware sets the event on the same edge as the clear, the set wins.
- R8: Halted reads 0 from the edge that writes run=1, and it stays 0 while run is 1.
- R9: After a write of run=0, halted rises on the STOP_LAT-th consecutive clock edge with `walk_busy`=0, counting from the edge after the write. An edge with `walk_busy`=1 restarts that count.
- R10: Writing run=1 while a stop is still pending cancels the stop, and halted stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the command register, 1 selects the status register |
| wr_data | input | 8 | Write data |
| walk_safe | input | 1 | Walker is at an idle or safe point this cycle |
| walk_busy | input | 1 | A walker step is in progress |
| evict_done | input | 1 | Async advance and cache eviction have completed |
| cmd_rd | output | 8 | Command readback: run[0], periodic enable[1], async enable[2], doorbell[3], light reset[4]=0 |
| sts_rd | output | 8 | Status readback: halted[0], periodic status[1], async status[2], advance event[3] |

## Verification
The bench builds the block with STOP_LAT=3. At that value every stop latency, with 0 to 3 busy edges inserted, can be walked edge by edge and checked for the exact edge on which halted rises.

The narrow command field lets the bench sweep all 32 command codes. It also sweeps every combination of previous enable, next enable and safe-point level for the two status trackers. The doorbell is driven through ring, ignored ring, write-0, eviction and simultaneous set/clear sequences, with expected values derived from the requirements.

// File: rtl/hc_sched_pkg.sv
package hc_sched_pkg;

    localparam int WR_W    = 8;
    localparam int N_SCHED = 2;

    // command register bit positions
    localparam int BIT_RUN  = 0;
    localparam int BIT_PER  = 1;
    localparam int BIT_ASY  = 2;
    localparam int BIT_DB   = 3;
    localparam int BIT_LRST = 4;

    // status register bit positions
    localparam int ST_HALT = 0;
    localparam int ST_PER  = 1;
    localparam int ST_ASY  = 2;
    localparam int ST_ADV  = 3;

    // schedule index in the enable/status vectors
    localparam int SCH_PER = 0;
    localparam int SCH_ASY = 1;

    typedef enum logic [1:0] {
        HS_RUN      = 2'd0,
        HS_STOPPING = 2'd1,
        HS_HALTED   = 2'd2
    } halt_st_e;

    typedef enum logic [1:0] {
        DB_IDLE = 2'd0,
        DB_WAIT = 2'd1,
        DB_ACK  = 2'd2
    } db_st_e;

    typedef struct packed {
        logic               run;
        logic [N_SCHED-1:0] sched_en;
    } cmd_t;

    typedef struct packed {
        logic ring;
        logic adv_clr;
        logic run_wr;
        logic run_val;
    } wr_evt_t;

    function automatic logic [WR_W-1:0] pack_cmd(cmd_t c, logic db);
        logic [WR_W-1:0] v;
        v           = '0;
        v[BIT_RUN]  = c.run;
        v[BIT_PER]  = c.sched_en[SCH_PER];
        v[BIT_ASY]  = c.sched_en[SCH_ASY];
        v[BIT_DB]   = db;
        v[BIT_LRST] = 1'b0;
        return v;
    endfunction

    function automatic logic [WR_W-1:0] pack_sts(logic halted, logic [N_SCHED-1:0] sts, logic adv);
        logic [WR_W-1:0] v;
        v          = '0;
        v[ST_HALT] = halted;
        v[ST_PER]  = sts[SCH_PER];
        v[ST_ASY]  = sts[SCH_ASY];
        v[ST_ADV]  = adv;
        return v;
    endfunction

endpackage

// File: rtl/hc_cmd_regs.sv
module hc_cmd_regs
    import hc_sched_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [WR_W-1:0] wr_data,
    output cmd_t            cmd_q,
    output wr_evt_t         evt
);

    logic cmd_wr;
    logic sts_wr;
    logic unused_hi_bits;

    assign cmd_wr = wr_en && !wr_sel;
    assign sts_wr = wr_en && wr_sel;

    // light-reset and upper bits carry no state
    assign unused_hi_bits = ^wr_data[WR_W-1:BIT_LRST];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (cmd_wr) begin
            cmd_q.run               <= wr_data[BIT_RUN];
            cmd_q.sched_en[SCH_PER] <= wr_data[BIT_PER];
            cmd_q.sched_en[SCH_ASY] <= wr_data[BIT_ASY];
        end
    end

    always_comb begin
        evt.ring    = cmd_wr && wr_data[BIT_DB];
        evt.adv_clr = sts_wr && wr_data[ST_ADV];
        evt.run_wr  = cmd_wr;
        evt.run_val = wr_data[BIT_RUN];
    end

    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_wr) |-> $stable(cmd_q));

endmodule

// File: rtl/hc_sched_track.sv
module hc_sched_track (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic safe,
    output logic sts
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= 1'b0;
        end else if (safe) begin
            sts <= en;
        end
    end

    // R3: no status movement away from a safe point
    a_r3_hold_off_safe: assert property (@(posedge clk) disable iff (rst)
        !$past(safe) |-> $stable(sts));

    a_r3_change_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (sts != $past(sts)) |-> (sts == $past(en)));

endmodule

// File: rtl/hc_doorbell.sv
module hc_doorbell
    import hc_sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ring,
    input  logic asy_sts,
    input  logic evict_done,
    input  logic adv_clr,
    output logic db,
    output logic adv_evt
);

    db_st_e st;
    logic   post;

    assign post = (st == DB_WAIT) && evict_done;
    assign db   = (st != DB_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= DB_IDLE;
        end else begin
            unique case (st)
                DB_IDLE: if (ring && asy_sts) st <= DB_WAIT;
                DB_WAIT: if (evict_done) st <= DB_ACK;
                DB_ACK:  st <= DB_IDLE;
                default: st <= DB_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            adv_evt <= 1'b0;
        end else if (post) begin
            adv_evt <= 1'b1;
        end else if (adv_clr) begin
            adv_evt <= 1'b0;
        end
    end

    a_r4_ring_needs_async: assert property (@(posedge clk) disable iff (rst)
        $rose(db) |-> ($past(asy_sts) && $past(ring)));

    a_r5_event_source: assert property (@(posedge clk) disable iff (rst)
        $rose(adv_evt) |-> ($past(db) && $past(evict_done)));

    a_r6_clear_after_event: assert property (@(posedge clk) disable iff (rst)
        $fell(db) |-> $past(adv_evt));

    a_r7_clear_by_write: assert property (@(posedge clk) disable iff (rst)
        $fell(adv_evt) |-> $past(adv_clr));

endmodule

// File: rtl/hc_halt_ctl.sv
module hc_halt_ctl
    import hc_sched_pkg::*;
#(
    parameter int STOP_LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_wr,
    input  logic run_val,
    input  logic walk_busy,
    output logic halted
);

    localparam int              CNT_W = $clog2(STOP_LAT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STOP_LAT - 1);

    halt_st_e         st;
    logic [CNT_W-1:0] cnt;

    assign halted = (st == HS_HALTED);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= HS_HALTED;
            cnt <= '0;
        end else if (run_wr && run_val) begin
            st  <= HS_RUN;
            cnt <= '0;
        end else if (run_wr && (st == HS_RUN)) begin
            st  <= HS_STOPPING;
            cnt <= '0;
        end else if (st == HS_STOPPING) begin
            if (walk_busy) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                st  <= HS_HALTED;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r9_rise_when_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> (!$past(walk_busy) && !$past(run_wr && run_val)));

    a_r10_run_write_unhalts: assert property (@(posedge clk) disable iff (rst)
        $past(run_wr && run_val) |-> !halted);

endmodule

// File: rtl/hc_sched_handshake.sv
module hc_sched_handshake
    import hc_sched_pkg::*;
#(
    parameter int STOP_LAT = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [WR_W-1:0] wr_data,
    input  logic            walk_safe,
    input  logic            walk_busy,
    input  logic            evict_done,
    output logic [WR_W-1:0] cmd_rd,
    output logic [WR_W-1:0] sts_rd
);

    cmd_t               cmd_q;
    wr_evt_t            evt;
    logic [N_SCHED-1:0] sched_sts;
    logic               db;
    logic               adv_evt;
    logic               halted;

    hc_cmd_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cmd_q   (cmd_q),
        .evt     (evt)
    );

    for (genvar g = 0; g < N_SCHED; g++) begin : g_trk
        hc_sched_track u_trk (
            .clk  (clk),
            .rst  (rst),
            .en   (cmd_q.sched_en[g]),
            .safe (walk_safe),
            .sts  (sched_sts[g])
        );
    end

    hc_doorbell u_db (
        .clk        (clk),
        .rst        (rst),
        .ring       (evt.ring),
        .asy_sts    (sched_sts[SCH_ASY]),
        .evict_done (evict_done),
        .adv_clr    (evt.adv_clr),
        .db         (db),
        .adv_evt    (adv_evt)
    );

    hc_halt_ctl #(.STOP_LAT(STOP_LAT)) u_halt (
        .clk       (clk),
        .rst       (rst),
        .run_wr    (evt.run_wr),
        .run_val   (evt.run_val),
        .walk_busy (walk_busy),
        .halted    (halted)
    );

    assign cmd_rd = pack_cmd(cmd_q, db);
    assign sts_rd = pack_sts(halted, sched_sts, adv_evt);

    a_r8_run_not_halted: assert property (@(posedge clk) disable iff (rst)
        cmd_q.run |-> !halted);

    a_r4_doorbell_async_on: assert property (@(posedge clk) disable iff (rst)
        (db && !$past(db)) |-> $past(sched_sts[SCH_ASY]));

endmodule

// File: tb/tb_hc_sched_handshake.sv
module tb_hc_sched_handshake;

    localparam int L = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic       wr_sel;
    logic [7:0] wr_data;
    logic       walk_safe;
    logic       walk_busy;
    logic       evict_done;
    logic [7:0] cmd_rd;
    logic [7:0] sts_rd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hc_sched_handshake #(.STOP_LAT(L)) dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .walk_safe  (walk_safe),
        .walk_busy  (walk_busy),
        .evict_done (evict_done),
        .cmd_rd     (cmd_rd),
        .sts_rd     (sts_rd)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_sel  = sel;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic safe_pulse();
        walk_safe = 1'b1;
        step(1);
        walk_safe = 1'b0;
    endtask

    task automatic evict_pulse();
        evict_done = 1'b1;
        step(1);
        evict_done = 1'b0;
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
        walk_safe = 1'b0; walk_busy = 1'b0; evict_done = 1'b0;
        step(3);
        chk("R1 cmd reset", int'(cmd_rd), 0);
        chk("R1 sts reset", int'(sts_rd), 1);
        rst = 1'b0;
        step(1);

        // R2 / R4 / R3: full command sweep, async status is 0 and no safe point
        for (int v = 0; v < 32; v++) begin
            wr(1'b0, 8'(v));
            chk("R2 cmd readback (bit4 reads 0, bit3 gated by R4)", int'(cmd_rd), v & 7);
            chk("R3 status frozen off safe point", int'(sts_rd[2:1]), 0);
        end
        wr(1'b0, 8'h00);
        step(L + 1);

        // R3 sweep over previous enable, next enable, safe level
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 4; n++) begin
                for (int s = 0; s < 2; s++) begin
                    wr(1'b0, 8'(p << 1));
                    safe_pulse();
                    chk("R3 status takes enable at safe", int'(sts_rd[2:1]), p);
                    wr(1'b0, 8'(n << 1));
                    chk("R3 status holds after enable write", int'(sts_rd[2:1]), p);
                    walk_safe = s[0];
                    step(1);
                    walk_safe = 1'b0;
                    chk("R3 status after edge", int'(sts_rd[2:1]), (s == 1) ? n : p);
                end
            end
        end

        // doorbell with async status active
        wr(1'b0, 8'h04);
        safe_pulse();
        chk("R3 async status on", int'(sts_rd[2]), 1);
        evict_pulse();
        chk("R5 evict without doorbell", int'(sts_rd[3]), 0);
        wr(1'b0, 8'h0C);
        chk("R4 ring latches", int'(cmd_rd[3]), 1);
        wr(1'b0, 8'h04);
        chk("R4 write 0 keeps doorbell", int'(cmd_rd[3]), 1);
        step(3);
        chk("R6 doorbell held before event", int'(cmd_rd[3]), 1);
        chk("R5 no event before evict", int'(sts_rd[3]), 0);
        evict_pulse();
        chk("R5 event set", int'(sts_rd[3]), 1);
        chk("R6 doorbell still set on event edge", int'(cmd_rd[3]), 1);
        step(1);
        chk("R6 doorbell cleared next edge", int'(cmd_rd[3]), 0);
        wr(1'b1, 8'h00);
        chk("R7 write 0 keeps event", int'(sts_rd[3]), 1);
        wr(1'b1, 8'hF7);
        chk("R7 other bits keep event", int'(sts_rd[3]), 1);
        wr(1'b1, 8'h08);
        chk("R7 write 1 clears event", int'(sts_rd[3]), 0);

        // set wins over same-edge clear
        wr(1'b0, 8'h0C);
        evict_done = 1'b1;
        wr(1'b1, 8'h08);
        evict_done = 1'b0;
        chk("R7 set wins over clear", int'(sts_rd[3]), 1);
        step(1);
        chk("R6 doorbell cleared after set", int'(cmd_rd[3]), 0);
        wr(1'b1, 8'h08);
        chk("R7 cleared", int'(sts_rd[3]), 0);

        // ignored ring with async status 0
        wr(1'b0, 8'h00);
        safe_pulse();
        chk("R3 async status off", int'(sts_rd[2]), 0);
        wr(1'b0, 8'h08);
        chk("R4 ring ignored when async off", int'(cmd_rd[3]), 0);
        evict_pulse();
        chk("R5 no event after ignored ring", int'(sts_rd[3]), 0);

        // halt latency with 0..3 busy edges
        for (int b = 0; b < 4; b++) begin
            wr(1'b0, 8'h01);
            chk("R8 halted clears on run", int'(sts_rd[0]), 0);
            step(2);
            chk("R8 halted stays 0 while running", int'(sts_rd[0]), 0);
            walk_busy = (b > 0);
            wr(1'b0, 8'h00);
            for (int k = 1; k <= b + L; k++) begin
                walk_busy = (k <= b);
                step(1);
                if (k == b + L - 1) chk("R9 not yet halted", int'(sts_rd[0]), 0);
                if (k == b + L)     chk("R9 halted at latency", int'(sts_rd[0]), 1);
            end
            walk_busy = 1'b0;
        end

        // cancel pending stop
        wr(1'b0, 8'h01);
        wr(1'b0, 8'h00);
        step(1);
        wr(1'b0, 8'h01);
        step(L + 2);
        chk("R10 stop cancelled", int'(sts_rd[0]), 0);
        chk("R10 run kept", int'(cmd_rd[0]), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule